// File: doc/BRIEF.md
# TDM Multi-Slot Serial Receiver

This block is the receive half of a synchronous serial port run in multi-slot (network) mode. A serial bit clock, frame sync and data line arrive from outside the chip. The block samples them inside the system clock domain. At each falling edge of the selected bit clock the data line is sampled and shifted into a word assembler, most significant bit first. When a full word has been collected the word is copied into a holding register that software reads. A data-ready flag is raised and, if enabled, an interrupt request is raised too.

Every time slot of the frame produces a word, and the block does not filter slots. So that software can keep the words it wants and drop the rest, each word is tagged with the number of the slot it arrived in. A one-bit-wide frame sync resets the slot numbering. A word that software leaves unread when the next word lands raises a sticky overrun flag, and the new word replaces the old one. One mode input chooses where the bit clock and frame sync come from: the receiver's own pins, or the pins of the neighbouring transmitter.

Top module: `tdm_net_rx`

## Requirements
- R1: The data line is sampled once at each falling edge of the selected bit clock, seen as high in one system clock cycle and low in the next. Bits fill the word most significant bit first.
- R2: After the last bit of a word, `rx_data` holds that word from the next system clock edge. It stays unchanged until the next word completes.
- R3: `rx_ready` goes to 1 at every word completion, in every slot.
- R4: `rx_irq` is 1 exactly when `rx_ready` is 1 and `rx_int_en` is 1.
- R5: A one-cycle pulse on `rd_data_stb` clears `rx_ready`, and therefore `rx_irq`, unless a word completes in that same cycle.
- R6: If a word completes while `rx_ready` is still 1 and no data read happens in that cycle, `rx_overrun` becomes 1. `rx_data` then takes the newest word.
- R7: `rx_overrun` stays 1 until a `rd_stat_stb` pulse seen while it is 1 is followed by a `rd_data_stb` pulse. A data read alone does not clear it.
- R8: The frame sync is sampled at bit clock falls. A 0-to-1 change between two consecutive samples means the next sampled bit is the most significant bit of slot 0. Before the first such change, no word is produced.
- R9: `rx_slot` gives the slot number (0 to SLOTS-1) of the word in `rx_data`. The slot number counts up per word and wraps from SLOTS-1 to 0. A frame sync forces the next word to slot 0.
- R10: With `sync_mode`=1 the block uses `tx_bclk` and `tx_fsync`, and `rx_bclk` and `rx_fsync` have no effect. With `sync_mode`=0 the reverse holds.
- R11: After reset, `rx_data`=0, `rx_slot`=0, and `rx_ready`, `rx_overrun` and `rx_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: use transmitter clock and frame sync; 0: use own |
| rx_bclk | input | 1 | Receiver's own bit clock |
| rx_fsync | input | 1 | Receiver's own frame sync |
| tx_bclk | input | 1 | Transmitter bit clock |
| tx_fsync | input | 1 | Transmitter frame sync |
| sdata | input | 1 | Serial data line |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_data_stb | input | 1 | Read strobe for the holding register |
| rd_stat_stb | input | 1 | Read strobe for the status |
| rx_data | output | WORD_W | Holding register |
| rx_slot | output | SLOT_W | Slot number of the held word |
| rx_ready | output | 1 | Data-ready flag |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A bit counter that drifts by even one position shows up on `rx_data` at the very next word boundary: every later word comes out rotated. A drift in the slot counter shows up as a wrong `rx_slot` at that same boundary, one word period after the fault. Flag state errors show up within one system clock cycle. A stuck ready flag appears as a missing clear after a read, and a lost arm state appears as an overrun flag that will not clear. The bench therefore compares every output against its model on every cycle.

// File: rtl/rxtdm_pkg.sv
package rxtdm_pkg;

    // Source of bit clock and frame sync
    typedef enum logic {
        SRC_OWN = 1'b0,
        SRC_TX  = 1'b1
    } clk_src_e;

    // One sampled serial event in the system clock domain
    typedef struct packed {
        logic fall;     // selected bit clock just fell
        logic dat;      // serial data level
        logic fs_rise;  // frame sync sampled 1 after a 0 sample
    } bit_evt_t;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rxtdm_front.sv
module rxtdm_front
    import rxtdm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_mode,
    input  logic     rx_bclk,
    input  logic     rx_fsync,
    input  logic     tx_bclk,
    input  logic     tx_fsync,
    input  logic     sdata,
    output bit_evt_t evt
);
    clk_src_e src;
    logic     bclk_sel;
    logic     fs_sel;
    logic     bclk_q;
    logic     fs_q;

    assign src = clk_src_e'(sync_mode);

    always_comb begin
        unique case (src)
            SRC_TX: begin
                bclk_sel = tx_bclk;
                fs_sel   = tx_fsync;
            end
            default: begin
                bclk_sel = rx_bclk;
                fs_sel   = rx_fsync;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            fs_q   <= 1'b0;
        end else begin
            bclk_q <= bclk_sel;
            if (bclk_q && !bclk_sel) begin
                fs_q <= fs_sel;
            end
        end
    end

    always_comb begin
        evt.fall    = bclk_q & ~bclk_sel;
        evt.dat     = sdata;
        evt.fs_rise = fs_sel & ~fs_q;
    end

endmodule

// File: rtl/rxtdm_deser.sv
module rxtdm_deser
    import rxtdm_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned SLOTS  = 5,
    localparam int unsigned BIT_W  = cnt_bits(WORD_W),
    localparam int unsigned SLOT_W = cnt_bits(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          evt,
    output logic              word_evt,
    output logic [WORD_W-1:0] word,
    output logic [SLOT_W-1:0] word_slot
);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic              active;
    logic [BIT_W-1:0]  bit_cnt;
    logic [SLOT_W-1:0] slot_cnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shifted;
    logic              last_bit;

    assign shifted  = {shreg[WORD_W-2:0], evt.dat};
    assign last_bit = active && (bit_cnt == LAST_BIT);

    assign word_evt  = evt.fall && last_bit;
    assign word      = shifted;
    assign word_slot = slot_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            bit_cnt  <= '0;
            slot_cnt <= '0;
            shreg    <= '0;
        end else if (evt.fall) begin
            if (active) begin
                shreg <= shifted;
                if (last_bit) begin
                    bit_cnt  <= '0;
                    slot_cnt <= (slot_cnt == LAST_SLOT) ? '0 : slot_cnt + 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (evt.fs_rise) begin
                active   <= 1'b1;
                bit_cnt  <= '0;
                slot_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/rxtdm_hold.sv
module rxtdm_hold
    import rxtdm_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned SLOTS  = 5,
    localparam int unsigned SLOT_W = cnt_bits(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_evt,
    input  logic [WORD_W-1:0] word,
    input  logic [SLOT_W-1:0] word_slot,
    input  logic              rd_data_stb,
    input  logic              rd_stat_stb,
    input  logic              int_en,
    output logic [WORD_W-1:0] data,
    output logic [SLOT_W-1:0] slot,
    output logic              ready,
    output logic              overrun,
    output logic              irq
);
    logic clr_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            data      <= '0;
            slot      <= '0;
            ready     <= 1'b0;
            overrun   <= 1'b0;
            clr_armed <= 1'b0;
        end else begin
            if (word_evt) begin
                data <= word;
                slot <= word_slot;
            end
            ready <= word_evt | (ready & ~rd_data_stb);
            if (word_evt && ready && !rd_data_stb) begin
                overrun <= 1'b1;
            end else if (rd_data_stb && clr_armed) begin
                overrun <= 1'b0;
            end
            if (rd_data_stb) begin
                clr_armed <= 1'b0;
            end else if (rd_stat_stb && overrun) begin
                clr_armed <= 1'b1;
            end
        end
    end

    assign irq = ready & int_en;

endmodule

// File: rtl/tdm_net_rx.sv
module tdm_net_rx
    import rxtdm_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned SLOTS  = 5,
    localparam int unsigned SLOT_W = cnt_bits(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_mode,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    input  logic              sdata,
    input  logic              rx_int_en,
    input  logic              rd_data_stb,
    input  logic              rd_stat_stb,
    output logic [WORD_W-1:0] rx_data,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              rx_ready,
    output logic              rx_overrun,
    output logic              rx_irq
);
    bit_evt_t          evt;
    logic              word_evt;
    logic [WORD_W-1:0] word;
    logic [SLOT_W-1:0] word_slot;

    rxtdm_front u_front (
        .clk       (clk),
        .rst       (rst),
        .sync_mode (sync_mode),
        .rx_bclk   (rx_bclk),
        .rx_fsync  (rx_fsync),
        .tx_bclk   (tx_bclk),
        .tx_fsync  (tx_fsync),
        .sdata     (sdata),
        .evt       (evt)
    );

    rxtdm_deser #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .word_evt  (word_evt),
        .word      (word),
        .word_slot (word_slot)
    );

    rxtdm_hold #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .word_evt    (word_evt),
        .word        (word),
        .word_slot   (word_slot),
        .rd_data_stb (rd_data_stb),
        .rd_stat_stb (rd_stat_stb),
        .int_en      (rx_int_en),
        .data        (rx_data),
        .slot        (rx_slot),
        .ready       (rx_ready),
        .overrun     (rx_overrun),
        .irq         (rx_irq)
    );

endmodule

// File: rtl/tdm_net_rx_chk.sv
module tdm_net_rx_chk #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned SLOTS  = 5,
    parameter int unsigned SLOT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              word_evt,
    input logic              rd_data_stb,
    input logic              rx_ready,
    input logic              rx_overrun,
    input logic [WORD_W-1:0] rx_data,
    input logic [SLOT_W-1:0] rx_slot
);
    // R2: holding register changes only on a word completion
    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !word_evt |=> $stable(rx_data));

    // R3: ready rises only after a word completion
    p_ready_src_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(word_evt));

    // R5: a data read without a new word clears ready
    p_read_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_data_stb && !word_evt) |=> !rx_ready);

    // R6: overrun only rises when an unread word was pending
    p_ovr_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_ready && word_evt));

    // R7: overrun is sticky unless a data read happens
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !rd_data_stb) |=> rx_overrun);

    // R9: slot tag stays within the frame
    p_slot_range_r9: assert property (@(posedge clk) disable iff (rst)
        32'(rx_slot) < SLOTS);

endmodule

bind tdm_net_rx tdm_net_rx_chk #(
    .WORD_W (WORD_W),
    .SLOTS  (SLOTS),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .word_evt    (word_evt),
    .rd_data_stb (rd_data_stb),
    .rx_ready    (rx_ready),
    .rx_overrun  (rx_overrun),
    .rx_data     (rx_data),
    .rx_slot     (rx_slot)
);

// File: tb/tdm_net_rx_tb_top.sv
module tdm_net_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 8;
    localparam int SLOTS  = 5;
    localparam int SLOT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_mode = 1'b0;
    logic rx_bclk = 1'b0, rx_fsync = 1'b0, tx_bclk = 1'b0, tx_fsync = 1'b0;
    logic sdata = 1'b0, rx_int_en = 1'b1;
    logic rd_data_stb = 1'b0, rd_stat_stb = 1'b0;
    logic [WORD_W-1:0] rx_data;
    logic [SLOT_W-1:0] rx_slot;
    logic rx_ready, rx_overrun, rx_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_net_rx #(.WORD_W(WORD_W), .SLOTS(SLOTS)) dut_i (
        .clk(clk), .rst(rst), .sync_mode(sync_mode),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync),
        .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
        .sdata(sdata), .rx_int_en(rx_int_en),
        .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
        .rx_data(rx_data), .rx_slot(rx_slot), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_irq(rx_irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_prev_clk, m_prev_fs, m_active, m_slot;
    int m_data, m_wslot, m_ready, m_ovr, m_armed;
    bit m_bits[$];

    always @(posedge clk) begin
        int c, f, got, w;
        if (rst) begin
            m_prev_clk = 0; m_prev_fs = 0; m_active = 0; m_slot = 0;
            m_data = 0; m_wslot = 0; m_ready = 0; m_ovr = 0; m_armed = 0;
            m_bits.delete();
        end else begin
            c = sync_mode ? int'(tx_bclk) : int'(rx_bclk);
            f = sync_mode ? int'(tx_fsync) : int'(rx_fsync);
            got = 0;
            if (m_prev_clk == 1 && c == 0) begin
                int rise;
                rise = (f == 1 && m_prev_fs == 0);
                m_prev_fs = f;
                if (m_active != 0) begin
                    m_bits.push_back(sdata);
                    if (m_bits.size() == WORD_W) begin
                        w = 0;
                        foreach (m_bits[i]) w = w * 2 + int'(m_bits[i]);
                        m_bits.delete();
                        got = 1;
                        m_data = w;
                        m_wslot = m_slot;
                        m_slot = (m_slot + 1) % SLOTS;
                    end
                end
                if (rise) begin
                    m_active = 1;
                    m_bits.delete();
                    m_slot = 0;
                end
            end
            m_prev_clk = c;
            if (got == 1 && m_ready == 1 && !rd_data_stb) m_ovr = 1;
            else if (rd_data_stb && m_armed == 1) m_ovr = 0;
            if (rd_data_stb) m_armed = 0;
            else if (rd_stat_stb && m_ovr == 1) m_armed = 1;
            if (got == 1) m_ready = 1;
            else if (rd_data_stb) m_ready = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (live && !rst && !done) begin
            chk("R2 rx_data", int'(rx_data), m_data);
            chk("R9 rx_slot", int'(rx_slot), m_wslot);
            chk("R3 rx_ready", int'(rx_ready), m_ready);
            chk("R6 rx_overrun", int'(rx_overrun), m_ovr);
            chk("R4 rx_irq", int'(rx_irq), (m_ready == 1 && rx_int_en) ? 1 : 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_bit(input bit d, input bit fs);
        @(negedge clk);
        if (sync_mode) begin
            tx_bclk = 1'b1; tx_fsync = fs; rx_bclk = 1'b1; rx_fsync = ~fs;
        end else begin
            rx_bclk = 1'b1; rx_fsync = fs; tx_bclk = 1'b1; tx_fsync = ~fs;
        end
        sdata = d;
        @(negedge clk);
        @(negedge clk);
        rx_bclk = 1'b0; tx_bclk = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_word(input logic [WORD_W-1:0] v, input bit fs_last);
        for (int i = WORD_W - 1; i >= 0; i--) send_bit(v[i], (i == 0) ? fs_last : 1'b0);
    endtask

    task automatic read_data();
        rd_data_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0;
    endtask

    task automatic read_stat();
        rd_stat_stb = 1'b1;
        @(negedge clk);
        rd_stat_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11 data", int'(rx_data), 0);
        chk("R11 slot", int'(rx_slot), 0);
        chk("R11 flags", int'({rx_ready, rx_overrun, rx_irq}), 0);
        live = 1'b1;

        // R8: no words before the first frame sync
        for (int i = 0; i < 11; i++) send_bit(i[0], 1'b0);
        chk("R8 no word before sync", int'(rx_ready), 0);

        send_bit(1'b0, 1'b1);
        send_word(8'hA5, 1'b0);
        chk("R1 msb first", int'(rx_data), 'hA5);
        chk("R9 slot0", int'(rx_slot), 0);
        read_data();
        chk("R5 ready cleared", int'(rx_ready), 0);
        chk("R5 irq cleared", int'(rx_irq), 0);

        send_word(8'h3C, 1'b0);
        chk("R3 ready slot1", int'(rx_ready), 1);
        send_word(8'hFF, 1'b0);
        chk("R6 overrun set", int'(rx_overrun), 1);
        chk("R6 newest kept", int'(rx_data), 'hFF);
        chk("R9 slot2", int'(rx_slot), 2);
        read_data();
        chk("R7 data read alone", int'(rx_overrun), 1);
        read_stat();
        send_word(8'h00, 1'b0);
        chk("R7 still set", int'(rx_overrun), 1);
        read_data();
        chk("R7 cleared", int'(rx_overrun), 0);
        send_word(8'h81, 1'b1);
        chk("R9 slot4", int'(rx_slot), 4);
        read_data();

        // second frame, interrupt masked then enabled
        rx_int_en = 1'b0;
        send_word(8'h5A, 1'b0);
        chk("R8 resync slot0", int'(rx_slot), 0);
        chk("R4 masked irq", int'(rx_irq), 0);
        rx_int_en = 1'b1;
        @(negedge clk);
        chk("R4 irq", int'(rx_irq), 1);
        read_data();
        for (int s = 1; s < SLOTS; s++) begin
            send_word(8'(8'h10 * s + s), 1'b0);
            chk("R9 wrap seq", int'(rx_slot), s);
            read_data();
        end

        // transmitter-sourced clocks
        sync_mode = 1'b1;
        @(negedge clk);
        send_bit(1'b1, 1'b1);
        send_word(8'hC3, 1'b0);
        chk("R10 tx source data", int'(rx_data), 'hC3);
        chk("R10 tx source slot", int'(rx_slot), 0);
        read_data();
        send_word(8'h6E, 1'b0);
        chk("R10 own lines ignored", int'(rx_data), 'h6E);
        read_data();

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule